// File: doc/BRIEF.md
# I2C bus timeout monitor

This block watches the synchronized clock and data lines of a two-wire serial bus, along with the controller's bus-busy indication. It detects two fault conditions. A clock-low timeout fires when the clock line is held low for too long. A bus idle timeout fires when the clock line stays high for too long while the bus is still considered busy and the data line does not move. Both counters advance only on a prescaled tick that comes from the controller's clock divider.

Each fault has its own encoded threshold select and its own single-cycle flag output. The controller's interrupt logic consumes these flags. An option turns the bus idle timeout into a request that drops the busy state and returns the controller to idle. When the peripheral is disabled, both counters are held at zero.

Top module: `i2c_timeout_mon`

## Requirements
- R1: After reset, and while no timeout condition is being counted, `clto_flag`, `bito_flag` and `go_idle` are low.
- R2: With `clto_sel` set to 1, 2, 3, 4 or 5, `clto_flag` pulses high for exactly one clock once `scl` has been sampled low for CL_THR1, CL_THR2, CL_THR3, CL_THR4 or CL_THR5 ticks (defaults 40, 80, 160, 320 and 1024). The pulse appears in the cycle after the clock edge that samples the last tick.
- R3: A `clto_sel` value of 0, 6 or 7 disables the clock-low timeout, so `clto_flag` never pulses.
- R4: Sampling `scl` high clears the clock-low count, so a later low period counts its full threshold from zero.
- R5: With `bito_sel` set to 1, 2 or 3, `bito_flag` pulses high for exactly one clock once `busy` is high, `scl` is high and `sda` is unchanged for BI_THR1, BI_THR2 or BI_THR3 ticks (defaults 40, 80 and 160).
- R6: A `bito_sel` value of 0 disables the bus idle timeout.
- R7: The bus idle count clears in any cycle where `scl` is low, `busy` is low, or `sda` differs from its value at the previous clock edge. Counting resumes from zero at the following edge.
- R8: Each flag pulses at most once per uninterrupted fault period. It does not pulse again until its count has been cleared.
- R9: Counts advance only at clock edges where `tick` is high.
- R10: While `enable` is low, both counts are held at zero and neither flag pulses. After `enable` rises, the full threshold is counted.
- R11: `go_idle` pulses together with `bito_flag` when `idle_on_bito` is high, and stays low when `idle_on_bito` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low holds both counts at zero |
| tick | input | 1 | Prescaled tick; counts advance only when high |
| scl | input | 1 | Synchronized clock line |
| sda | input | 1 | Synchronized data line |
| busy | input | 1 | Controller considers the bus busy |
| bito_sel | input | 2 | Bus idle threshold select (0 off, 1..3) |
| clto_sel | input | 3 | Clock-low threshold select (0, 6, 7 off, 1..5) |
| idle_on_bito | input | 1 | Bus idle timeout also requests return to idle |
| bito_flag | output | 1 | One-cycle bus idle timeout pulse |
| clto_flag | output | 1 | One-cycle clock-low timeout pulse |
| go_idle | output | 1 | One-cycle request to clear busy and go idle |

## Verification
The bench builds the monitor with reduced thresholds: bus idle 5, 9 and 14, and clock-low 3, 6, 10, 12 and 20. Every select code, including the largest clock-low setting, can therefore be driven to its pulse many times within a short run. These small values also let the bench repeat the threshold sweep under a tick that arrives only every third clock. A reference model in the bench predicts the exact cycle of each pulse from the tick pattern. It uses that prediction to check that interrupted periods restart from zero, that no second pulse follows a held fault, and that the disabled codes stay silent.

// File: rtl/i2c_timeout_mon.sv
module i2c_timeout_mon #(
  parameter int BI_THR1 = 40,
  parameter int BI_THR2 = 80,
  parameter int BI_THR3 = 160,
  parameter int CL_THR1 = 40,
  parameter int CL_THR2 = 80,
  parameter int CL_THR3 = 160,
  parameter int CL_THR4 = 320,
  parameter int CL_THR5 = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       scl,
  input  logic       sda,
  input  logic       busy,
  input  logic [1:0] bito_sel,
  input  logic [2:0] clto_sel,
  input  logic       idle_on_bito,
  output logic       bito_flag,
  output logic       clto_flag,
  output logic       go_idle
);

  localparam int BI_M12 = (BI_THR1 > BI_THR2) ? BI_THR1 : BI_THR2;
  localparam int BI_MAX = (BI_M12 > BI_THR3) ? BI_M12 : BI_THR3;
  localparam int CL_M12 = (CL_THR1 > CL_THR2) ? CL_THR1 : CL_THR2;
  localparam int CL_M34 = (CL_THR3 > CL_THR4) ? CL_THR3 : CL_THR4;
  localparam int CL_M14 = (CL_M12 > CL_M34) ? CL_M12 : CL_M34;
  localparam int CL_MAX = (CL_M14 > CL_THR5) ? CL_M14 : CL_THR5;
  localparam int BW = $clog2(BI_MAX + 1);
  localparam int CW = $clog2(CL_MAX + 1);

  logic [CW-1:0] cl_cnt, cl_thr, cl_nxt;
  logic [BW-1:0] bi_cnt, bi_thr, bi_nxt;
  logic          sda_q;
  logic          cl_clear, bi_clear;

  always_comb begin
    case (clto_sel)
      3'd1:    cl_thr = CW'(CL_THR1);
      3'd2:    cl_thr = CW'(CL_THR2);
      3'd3:    cl_thr = CW'(CL_THR3);
      3'd4:    cl_thr = CW'(CL_THR4);
      3'd5:    cl_thr = CW'(CL_THR5);
      default: cl_thr = '0;
    endcase
    case (bito_sel)
      2'd1:    bi_thr = BW'(BI_THR1);
      2'd2:    bi_thr = BW'(BI_THR2);
      2'd3:    bi_thr = BW'(BI_THR3);
      default: bi_thr = '0;
    endcase
  end

  assign cl_nxt   = cl_cnt + CW'(1);
  assign bi_nxt   = bi_cnt + BW'(1);
  assign cl_clear = !enable || scl || (cl_thr == '0);
  assign bi_clear = !enable || !busy || !scl || (sda != sda_q) || (bi_thr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_cnt    <= '0;
      clto_flag <= 1'b0;
    end else begin
      clto_flag <= 1'b0;
      if (cl_clear) begin
        cl_cnt <= '0;
      end else if (tick && (cl_cnt < cl_thr)) begin
        cl_cnt    <= cl_nxt;
        clto_flag <= (cl_nxt == cl_thr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q     <= 1'b1;
      bi_cnt    <= '0;
      bito_flag <= 1'b0;
    end else begin
      sda_q     <= sda;
      bito_flag <= 1'b0;
      if (bi_clear) begin
        bi_cnt <= '0;
      end else if (tick && (bi_cnt < bi_thr)) begin
        bi_cnt    <= bi_nxt;
        bito_flag <= (bi_nxt == bi_thr);
      end
    end
  end

  assign go_idle = bito_flag && idle_on_bito;

  p_clto_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clto_flag |=> !clto_flag);
  p_bito_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bito_flag |=> !bito_flag);
  p_clto_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clto_flag |-> $past(tick));
  p_bito_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bito_flag |-> $past(tick));
  p_clto_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clto_flag |-> $past(!scl));
  p_bito_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bito_flag |-> $past(busy && scl));
  p_clto_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clto_flag |-> ($past(clto_sel) >= 3'd1 && $past(clto_sel) <= 3'd5));
  p_bito_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bito_flag |-> ($past(bito_sel) != 2'd0));
  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (!clto_flag && !bito_flag));

endmodule

// File: tb/test_i2c_timeout_mon.sv
module test_i2c_timeout_mon;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, tick = 1'b0, scl = 1'b1, sda = 1'b1, busy = 1'b0;
  logic [1:0] bito_sel = '0;
  logic [2:0] clto_sel = '0;
  logic idle_on_bito = 1'b0;
  logic bito_flag, clto_flag, go_idle;

  i2c_timeout_mon #(.BI_THR1(5), .BI_THR2(9), .BI_THR3(14),
                    .CL_THR1(3), .CL_THR2(6), .CL_THR3(10), .CL_THR4(12), .CL_THR5(20))
    i_i2c_timeout_mon (.clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .scl(scl),
      .sda(sda), .busy(busy), .bito_sel(bito_sel), .clto_sel(clto_sel),
      .idle_on_bito(idle_on_bito), .bito_flag(bito_flag), .clto_flag(clto_flag),
      .go_idle(go_idle));

  typedef struct { int cyc; string req; } exp_t;
  exp_t q_cl[$], q_bi[$], q_gi[$];
  int cl_t[6] = '{0, 3, 6, 10, 12, 20};
  int bi_t[4] = '{0, 5, 9, 14};
  int checks = 0, errors = 0, cyc = 0, tick_every = 1, seen = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk); #1;
    tick = ((cyc + 1) % tick_every == 0);
  end

  function automatic int pulse_edge(int start, int thr);
    int n = 0;
    int e = start;
    while (1) begin
      if (e % tick_every == 0) begin
        n++;
        if (n == thr) return e;
      end
      e++;
    end
  endfunction

  task automatic expect_cl(int start, int thr, string req);
    q_cl.push_back('{pulse_edge(start, thr), req});
  endtask

  task automatic expect_bi(int start, int thr, string req, bit gi);
    int e = pulse_edge(start, thr);
    q_bi.push_back('{e, req});
    if (gi) q_gi.push_back('{e, req});
  endtask

  task automatic mon_one(logic f, ref exp_t q[$], input string name);
    exp_t x;
    if (!f) return;
    seen++;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL %s: unexpected %s pulse at cycle %0d, expected none", cur_req, name, cyc);
    end else begin
      x = q.pop_front();
      if (x.cyc != cyc) begin
        errors++;
        $display("FAIL %s: %s pulse at cycle %0d, expected %0d", x.req, name, cyc, x.cyc);
      end
    end
  endtask

  initial forever begin
    @(negedge clk); #1;
    mon_one(clto_flag, q_cl, "clto_flag");
    mon_one(bito_flag, q_bi, "bito_flag");
    mon_one(go_idle, q_gi, "go_idle");
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(string req);
    int left = q_cl.size() + q_bi.size() + q_gi.size();
    checks++;
    if (left != 0) begin
      errors++;
      $display("FAIL %s: %0d expected pulses missing, expected 0", req, left);
      q_cl.delete(); q_bi.delete(); q_gi.delete();
    end
  endtask

  task automatic quiet(int n, string req);
    int s0 = seen;
    cur_req = req;
    run(n);
    checks++;
    if (seen != s0) begin
      errors++;
      $display("FAIL %s: %0d pulses in quiet window, expected 0", req, seen - s0);
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    run(4);
    checks++;
    if (clto_flag !== 1'b0 || bito_flag !== 1'b0 || go_idle !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs %b%b%b in reset, expected 000", clto_flag, bito_flag, go_idle);
    end
    rst_n = 1'b1;
    run(2);
    enable = 1'b1;
    quiet(10, "R1");

    // R2, R8: every clock-low code, held well past the threshold
    for (int c = 1; c <= 5; c++) begin
      clto_sel = 3'(c); scl = 1'b0;
      cur_req = "R8";
      expect_cl(cyc + 1, cl_t[c], "R2");
      run(cl_t[c] + 8);
      drained("R2");
      scl = 1'b1;
      run(2);
    end

    // R3: disabled clock-low codes
    foreach (cl_t[i]) if (i == 0) begin end
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 5) continue;
      clto_sel = 3'(c); scl = 1'b0;
      quiet(30, "R3");
      scl = 1'b1;
      run(2);
    end

    // R4: a short high pulse restarts the count
    clto_sel = 3'd3; scl = 1'b0;
    quiet(6, "R4");
    scl = 1'b1;
    run(1);
    scl = 1'b0;
    expect_cl(cyc + 1, 10, "R4");
    run(14);
    drained("R4");
    scl = 1'b1;
    run(2);

    // R9: tick every third clock
    tick_every = 3;
    for (int c = 1; c <= 5; c++) begin
      clto_sel = 3'(c); scl = 1'b0;
      expect_cl(cyc + 1, cl_t[c], "R9");
      run(3 * cl_t[c] + 6);
      drained("R9");
      scl = 1'b1;
      run(2);
    end
    tick_every = 1;
    run(2);

    // R10: disabled peripheral holds the counts
    enable = 1'b0; clto_sel = 3'd5; scl = 1'b0;
    quiet(40, "R10");
    enable = 1'b1;
    expect_cl(cyc + 1, 20, "R10");
    run(24);
    drained("R10");
    scl = 1'b1; clto_sel = 3'd0;
    run(2);

    // R5, R11: every bus idle code with go-idle option
    idle_on_bito = 1'b1;
    for (int c = 1; c <= 3; c++) begin
      bito_sel = 2'(c); busy = 1'b1;
      cur_req = "R8";
      expect_bi(cyc + 1, bi_t[c], "R5", 1'b1);
      run(bi_t[c] + 8);
      drained("R11");
      busy = 1'b0;
      run(2);
    end

    // R11: option off, flag without go_idle
    idle_on_bito = 1'b0; bito_sel = 2'd2; busy = 1'b1;
    expect_bi(cyc + 1, 9, "R11", 1'b0);
    run(14);
    drained("R11");
    busy = 1'b0;
    run(2);

    // R6: disabled bus idle code
    bito_sel = 2'd0; busy = 1'b1;
    quiet(30, "R6");
    busy = 1'b0;
    run(2);

    // R7: each clearing cause restarts the count
    idle_on_bito = 1'b1; bito_sel = 2'd3; busy = 1'b1;
    quiet(8, "R7");
    busy = 1'b0;
    run(1);
    busy = 1'b1;
    quiet(8, "R7");
    sda = 1'b0;
    expect_bi(cyc + 2, 14, "R7", 1'b1);
    run(18);
    drained("R7");
    busy = 1'b0;
    run(2);
    busy = 1'b1;
    quiet(8, "R7");
    scl = 1'b0;
    run(1);
    scl = 1'b1;
    expect_bi(cyc + 1, 14, "R7", 1'b1);
    run(18);
    drained("R7");
    busy = 1'b0;
    quiet(10, "R1");

    finish_run();
  end
endmodule